// File: doc/BRIEF.md
# Superscalar Register Rename Stage

This block renames a group of up to `IW` instructions in each cycle. Every slot of the group carries two source architectural registers and an optional destination. Each source is looked up in an architectural-to-physical map table. Each destination takes a fresh physical register from a free-list pop interface. The map table entry for that destination is then rewritten with the new register. Dependences inside the group are resolved by comparing each source against the destinations of all older slots in the same group. The table read and the comparison run side by side, and the comparison picks the final value. For every slot the block also reports the physical register that the destination was mapped to before, so that a later recovery can undo the write.

The group enters on a valid/ready handshake and leaves on a second valid/ready handshake. Both act in the same cycle, so the stage has no internal buffering. `in_ready` depends on `out_ready`, on the restore input and on the free-list count. The free-list count is compared with the number of destination-writing slots in the presented group. `in_ready` therefore depends on the group's contents, but never on `in_valid`. `out_valid` never depends on `out_ready`. A group is consumed, and the table updated, only in a cycle where `in_valid` and `in_ready` are both high. The producer must hold the group stable until that cycle.

A recovery port writes an (architectural, physical) pair straight into the table. It takes the cycle from any rename that is presented at the same time.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register a maps to physical register a for every a in 0..31.
- R2: A source with no older destination-writing slot naming the same architectural register in its group reports the table's current mapping for that register.
- R3: A source that matches the destination of one or more older slots in its group reports the new physical register of the nearest older matching slot (highest slot index below its own).
- R4: Destination-writing slots take the free-list candidates in slot order: the k-th such slot (counting from 0) reports `fl_preg[k]` on `out_pdst`. A slot without a destination reports 0 on `out_pdst` and on `out_pold`. `fl_pop` equals the number of destination-writing slots in a consumed group and is 0 in every other cycle.
- R5: `out_pold` of a destination-writing slot is the new register of the nearest older slot in the group with the same destination, or else the table's mapping for that destination.
- R6: After a group is consumed, each architectural register written by the group maps to the new register of the last slot that wrote it. All other entries are unchanged.
- R7: When the group needs more registers than `fl_avail` reports, `in_ready` and `out_valid` are 0 and `fl_pop` is 0. The table is left unchanged.
- R8: `out_valid` is `in_valid` when the group can proceed (no restore, enough registers). `in_ready` is 1 exactly when the group can proceed and `out_ready` is 1. With `out_ready` low, nothing is consumed.
- R9: When `restore_en` is 1, `restore_areg` maps to `restore_preg` from the next cycle on, and `in_ready` and `out_valid` are 0 for that cycle.
- R10: A source equal to its own slot's destination is not affected by that slot's write. It follows R2 or R3 using only the older slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Rename group presented |
| in_ready | output | 1 | Group consumed this cycle if in_valid |
| in_src1 | input | IW x 5 | First source architectural register per slot |
| in_src2 | input | IW x 5 | Second source architectural register per slot |
| in_dst | input | IW x 5 | Destination architectural register per slot |
| in_dst_en | input | IW | Slot writes a destination |
| fl_avail | input | clog2(IW+1) | Number of free-list candidates offered |
| fl_preg | input | IW x 6 | Free-list candidates, oldest first |
| fl_pop | output | clog2(IW+1) | Candidates consumed this cycle |
| out_valid | output | 1 | Renamed group available |
| out_ready | input | 1 | Downstream accepts the renamed group |
| out_psrc1 | output | IW x 6 | First source physical register per slot |
| out_psrc2 | output | IW x 6 | Second source physical register per slot |
| out_pdst | output | IW x 6 | New destination physical register per slot |
| out_pold | output | IW x 6 | Previous mapping of the destination per slot |
| restore_en | input | 1 | Write a recovery mapping this cycle |
| restore_areg | input | 5 | Architectural register to restore |
| restore_preg | input | 6 | Physical register to write back |

## Verification
The bench sweeps groups drawn from a narrow set of register names. As a result, sources often hit one, two or three older writers, and a slot often reads and writes the same register. A design with the wrong priority would return the farthest writer rather than the nearest. A design without an exclusive range in the comparison would forward a slot's own new register to its own sources. Groups that rewrite one destination several times probe both the previous-mapping output and the final table write. A first-wins table would leave a stale mapping that later reads expose, and a previous-mapping output without the group check would report the table value. Free-list shortages, downstream back-pressure and restores colliding with renames are mixed in. These cases show a design that pops registers or commits the table while stalled, or lets a rename win over a restore.

// File: rtl/rn_pkg.sv
package rn_pkg;

  localparam int RN_NUM_AREG_DEF = 32;
  localparam int RN_NUM_PREG_DEF = 64;
  localparam int RN_IW_DEF       = 4;

  // What the stage does with the presented group this cycle.
  typedef enum logic [1:0] {
    ACT_GO      = 2'd0,
    ACT_STALL   = 2'd1,
    ACT_RESTORE = 2'd2
  } rn_act_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_AREG = 32,
  parameter int NUM_PREG = 64,
  parameter int IW       = 4,
  localparam int AW = $clog2(NUM_AREG),
  localparam int PW = $clog2(NUM_PREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IW-1:0][AW-1:0]  rd1_a,
  input  logic [IW-1:0][AW-1:0]  rd2_a,
  input  logic [IW-1:0][AW-1:0]  rdd_a,
  output logic [IW-1:0][PW-1:0]  rd1_p,
  output logic [IW-1:0][PW-1:0]  rd2_p,
  output logic [IW-1:0][PW-1:0]  rdd_p,
  input  logic [IW-1:0]          wr_en,
  input  logic [IW-1:0][AW-1:0]  wr_a,
  input  logic [IW-1:0][PW-1:0]  wr_p,
  input  logic                   rs_en,
  input  logic [AW-1:0]          rs_a,
  input  logic [PW-1:0]          rs_p
);

  logic [PW-1:0] tbl [NUM_AREG];

  // Read ports: three per slot, combinational.
  for (genvar s = 0; s < IW; s++) begin : g_rd
    assign rd1_p[s] = tbl[rd1_a[s]];
    assign rd2_p[s] = tbl[rd2_a[s]];
    assign rdd_p[s] = tbl[rdd_a[s]];
  end

  // Write ports: a restore owns the cycle; otherwise slots write in order,
  // so the youngest writer of a register is the one that remains.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_AREG; a++) tbl[a] <= PW'(a);
    end else if (rs_en) begin
      tbl[rs_a] <= rs_p;
    end else begin
      for (int s = 0; s < IW; s++) begin
        if (wr_en[s]) tbl[wr_a[s]] <= wr_p[s];
      end
    end
  end

  AST_RESTORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    rs_en |=> tbl[$past(rs_a)] == $past(rs_p)); // R9
  AST_RESTORE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_en |-> wr_en == '0); // R9
  AST_LAST_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_en && wr_en[IW-1]) |=> tbl[$past(wr_a[IW-1])] == $past(wr_p[IW-1])); // R6

endmodule

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int NUM_PREG = 64,
  parameter int IW       = 4,
  localparam int PW = $clog2(NUM_PREG),
  localparam int CW = $clog2(IW + 1)
) (
  input  logic [IW-1:0]          dst_en,
  input  logic [CW-1:0]          fl_avail,
  input  logic [IW-1:0][PW-1:0]  fl_preg,
  output logic [IW-1:0][PW-1:0]  new_p,
  output logic [CW-1:0]          need,
  output logic                   enough
);

  // Prefix count over destination-writing slots hands out candidates in order.
  always_comb begin
    logic [CW-1:0] cnt;
    cnt   = '0;
    new_p = '0;
    for (int s = 0; s < IW; s++) begin
      if (dst_en[s]) begin
        for (int k = 0; k < IW; k++) begin
          if (CW'(k) == cnt) new_p[s] = fl_preg[k];
        end
      end
      cnt = cnt + {{(CW-1){1'b0}}, dst_en[s]};
    end
    need = cnt;
  end

  assign enough = (need <= fl_avail);

  always_comb begin
    AST_NEED_BOUND: assert (need <= CW'(IW)); // R4
  end

endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
  parameter int NUM_AREG = 32,
  parameter int NUM_PREG = 64,
  parameter int IW       = 4,
  localparam int AW = $clog2(NUM_AREG),
  localparam int PW = $clog2(NUM_PREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IW-1:0][AW-1:0]  src1,
  input  logic [IW-1:0][AW-1:0]  src2,
  input  logic [IW-1:0][AW-1:0]  dst,
  input  logic [IW-1:0]          dst_en,
  input  logic [IW-1:0][PW-1:0]  tbl1,
  input  logic [IW-1:0][PW-1:0]  tbl2,
  input  logic [IW-1:0][PW-1:0]  tbld,
  input  logic [IW-1:0][PW-1:0]  new_p,
  output logic [IW-1:0][PW-1:0]  psrc1,
  output logic [IW-1:0][PW-1:0]  psrc2,
  output logic [IW-1:0][PW-1:0]  pold
);

  for (genvar i = 0; i < IW; i++) begin : g_slot
    logic [PW-1:0] s1_v, s2_v, od_v;

    // Scan older slots from oldest to youngest; a later hit overrides, so the
    // nearest older writer decides. The slot's own write is never considered.
    always_comb begin
      s1_v = tbl1[i];
      s2_v = tbl2[i];
      od_v = tbld[i];
      for (int j = 0; j < i; j++) begin
        if (dst_en[j] && dst[j] == src1[i]) s1_v = new_p[j];
        if (dst_en[j] && dst[j] == src2[i]) s2_v = new_p[j];
        if (dst_en[j] && dst[j] == dst[i])  od_v = new_p[j];
      end
    end

    assign psrc1[i] = s1_v;
    assign psrc2[i] = s2_v;
    assign pold[i]  = dst_en[i] ? od_v : '0;

    if (i > 0) begin : g_near
      AST_NEAREST_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_en[i-1] && dst[i-1] == src1[i]) |-> psrc1[i] == new_p[i-1]); // R3
      AST_NEAREST_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_en[i] && dst_en[i-1] && dst[i-1] == dst[i]) |-> pold[i] == new_p[i-1]); // R5
    end else begin : g_first
      AST_FIRST_SLOT_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        psrc1[0] == tbl1[0] && psrc2[0] == tbl2[0]); // R2
    end
  end

endmodule

// File: rtl/rn_rename.sv
module rn_rename
  import rn_pkg::*;
#(
  parameter int NUM_AREG = RN_NUM_AREG_DEF,
  parameter int NUM_PREG = RN_NUM_PREG_DEF,
  parameter int IW       = RN_IW_DEF,
  localparam int AW = $clog2(NUM_AREG),
  localparam int PW = $clog2(NUM_PREG),
  localparam int CW = $clog2(IW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IW-1:0][AW-1:0]  in_src1,
  input  logic [IW-1:0][AW-1:0]  in_src2,
  input  logic [IW-1:0][AW-1:0]  in_dst,
  input  logic [IW-1:0]          in_dst_en,
  input  logic [CW-1:0]          fl_avail,
  input  logic [IW-1:0][PW-1:0]  fl_preg,
  output logic [CW-1:0]          fl_pop,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [IW-1:0][PW-1:0]  out_psrc1,
  output logic [IW-1:0][PW-1:0]  out_psrc2,
  output logic [IW-1:0][PW-1:0]  out_pdst,
  output logic [IW-1:0][PW-1:0]  out_pold,
  input  logic                   restore_en,
  input  logic [AW-1:0]          restore_areg,
  input  logic [PW-1:0]          restore_preg
);

  logic [IW-1:0][PW-1:0] tbl1, tbl2, tbld, new_p;
  logic [CW-1:0]         need;
  logic                  enough;
  logic                  fire;
  rn_act_e               act;

  rn_alloc #(.NUM_PREG(NUM_PREG), .IW(IW)) u_alloc (
    .dst_en   (in_dst_en),
    .fl_avail (fl_avail),
    .fl_preg  (fl_preg),
    .new_p    (new_p),
    .need     (need),
    .enough   (enough)
  );

  always_comb begin
    if (restore_en)   act = ACT_RESTORE;
    else if (!enough) act = ACT_STALL;
    else              act = ACT_GO;
  end

  assign out_valid = in_valid && (act == ACT_GO);
  assign in_ready  = (act == ACT_GO) && out_ready;
  assign fire      = in_valid && in_ready;
  assign fl_pop    = fire ? need : '0;

  rn_map_table #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG), .IW(IW)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .rd1_a (in_src1),
    .rd2_a (in_src2),
    .rdd_a (in_dst),
    .rd1_p (tbl1),
    .rd2_p (tbl2),
    .rdd_p (tbld),
    .wr_en (in_dst_en & {IW{fire}}),
    .wr_a  (in_dst),
    .wr_p  (new_p),
    .rs_en (restore_en),
    .rs_a  (restore_areg),
    .rs_p  (restore_preg)
  );

  rn_dep_check #(.NUM_AREG(NUM_AREG), .NUM_PREG(NUM_PREG), .IW(IW)) u_dep (
    .clk    (clk),
    .rst_n  (rst_n),
    .src1   (in_src1),
    .src2   (in_src2),
    .dst    (in_dst),
    .dst_en (in_dst_en),
    .tbl1   (tbl1),
    .tbl2   (tbl2),
    .tbld   (tbld),
    .new_p  (new_p),
    .psrc1  (out_psrc1),
    .psrc2  (out_psrc2),
    .pold   (out_pold)
  );

  assign out_pdst = new_p;

  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !enough |-> (fl_pop == '0 && !in_ready && !out_valid)); // R7
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop <= fl_avail); // R7
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> (!in_ready && fl_pop == '0)); // R8
  AST_RESTORE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> (!in_ready && !out_valid)); // R9
  AST_POP_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_pop != '0) |-> (in_valid && out_valid && out_ready)); // R4

endmodule

// File: tb/rn_rename_tb_top.sv
`timescale 1ns/1ps
module rn_rename_tb_top;

  localparam int IW = 4;
  localparam int NA = 32;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int CW = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid, in_ready, out_valid, out_ready;
  logic [IW-1:0][AW-1:0] in_src1, in_src2, in_dst;
  logic [IW-1:0]         in_dst_en;
  logic [CW-1:0]         fl_avail, fl_pop;
  logic [IW-1:0][PW-1:0] fl_preg, out_psrc1, out_psrc2, out_pdst, out_pold;
  logic                  restore_en;
  logic [AW-1:0]         restore_areg;
  logic [PW-1:0]         restore_preg;

  int n_checks = 0;
  int n_errors = 0;
  int mt [NA];

  always #2.5 clk = ~clk;

  rn_rename dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_dst_en(in_dst_en),
    .fl_avail(fl_avail), .fl_preg(fl_preg), .fl_pop(fl_pop),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
    .out_pdst(out_pdst), .out_pold(out_pold),
    .restore_en(restore_en), .restore_areg(restore_areg), .restore_preg(restore_preg)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // Called with inputs driven, after the negedge: checks the combinational
  // outputs, then commits the model as the next posedge will.
  task automatic check_and_commit(input string ctx);
    int need, k, e1, e2, eo, np [IW];
    bit ok, e_ready, e_valid, fire;
    string t1, t2;
    need = 0;
    for (int s = 0; s < IW; s++) begin
      np[s] = 0;
      if (in_dst_en[s]) begin np[s] = int'(fl_preg[need]); need++; end
    end
    ok      = !restore_en && (need <= int'(fl_avail));
    e_ready = ok && out_ready;
    e_valid = in_valid && ok;
    fire    = in_valid && e_ready;
    chk({"R8/R7/R9 in_ready ", ctx}, int'(in_ready), int'(e_ready));
    chk({"R8/R7/R9 out_valid ", ctx}, int'(out_valid), int'(e_valid));
    chk({"R4/R7 fl_pop ", ctx}, int'(fl_pop), fire ? need : 0);
    if (e_valid) begin
      for (int i = 0; i < IW; i++) begin
        e1 = mt[in_src1[i]]; e2 = mt[in_src2[i]];
        eo = in_dst_en[i] ? mt[in_dst[i]] : 0;
        t1 = (in_dst_en[i] && in_dst[i] == in_src1[i]) ? "R10" : "R2";
        t2 = (in_dst_en[i] && in_dst[i] == in_src2[i]) ? "R10" : "R2";
        k = 0;
        for (int j = 0; j < i; j++) begin
          if (in_dst_en[j] && in_dst[j] == in_src1[i]) begin e1 = np[j]; t1 = "R3"; end
          if (in_dst_en[j] && in_dst[j] == in_src2[i]) begin e2 = np[j]; t2 = "R3"; end
          if (in_dst_en[i] && in_dst_en[j] && in_dst[j] == in_dst[i]) eo = np[j];
        end
        chk({t1, " psrc1 ", ctx}, int'(out_psrc1[i]), e1);
        chk({t2, " psrc2 ", ctx}, int'(out_psrc2[i]), e2);
        chk({"R4 pdst ", ctx}, int'(out_pdst[i]), np[i]);
        chk({"R5 pold ", ctx}, int'(out_pold[i]), eo);
      end
    end
    if (restore_en) mt[restore_areg] = int'(restore_preg);
    else if (fire) begin
      for (int s = 0; s < IW; s++) if (in_dst_en[s]) mt[in_dst[s]] = np[s];
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; out_ready = 1'b1; restore_en = 1'b0;
    restore_areg = '0; restore_preg = '0;
    in_src1 = '0; in_src2 = '0; in_dst = '0; in_dst_en = '0;
    fl_avail = CW'(IW); fl_preg = '0;
  endtask

  // Reads the whole table back through source lookups (R1 after reset, R6 later).
  task automatic readback(input string tag);
    for (int g = 0; g < NA / (2 * IW); g++) begin
      @(negedge clk);
      idle_inputs();
      in_valid = 1'b1;
      for (int s = 0; s < IW; s++) begin
        in_src1[s] = AW'(g * 2 * IW + s);
        in_src2[s] = AW'(g * 2 * IW + IW + s);
      end
      #1;
      for (int s = 0; s < IW; s++) begin
        chk({tag, " table readback"}, int'(out_psrc1[s]), mt[in_src1[s]]);
        chk({tag, " table readback"}, int'(out_psrc2[s]), mt[in_src2[s]]);
      end
      check_and_commit(tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    for (int a = 0; a < NA; a++) mt[a] = a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    readback("R1");

    // Directed: three older writers of r3; slot 3 must see slot 2 (R3),
    // pold of slot 2 must be slot 1's register (R5), last write sticks (R6).
    @(negedge clk);
    idle_inputs();
    in_valid = 1'b1;
    in_dst = {5'd3, 5'd3, 5'd3, 5'd3}; in_dst_en = 4'b0111;
    in_src1 = {5'd3, 5'd3, 5'd3, 5'd3}; in_src2 = {5'd9, 5'd9, 5'd9, 5'd9};
    fl_preg = {6'd44, 6'd43, 6'd42, 6'd41};
    #1;
    chk("R3 directed nearest", int'(out_psrc1[3]), 43);
    chk("R10 directed own dst", int'(out_psrc1[0]), mt[3]);
    chk("R5 directed pold", int'(out_pold[2]), 42);
    check_and_commit("directed");
    readback("R6");

    // Directed stall: four writers but three candidates (R7).
    @(negedge clk);
    idle_inputs();
    in_valid = 1'b1; in_dst_en = 4'b1111; in_dst = {5'd1, 5'd2, 5'd4, 5'd5};
    fl_avail = 3'd3; fl_preg = {6'd60, 6'd61, 6'd62, 6'd63};
    #1;
    chk("R7 stall in_ready", int'(in_ready), 0);
    check_and_commit("stall");
    readback("R7 no update");

    // Directed restore colliding with a rename (R9).
    @(negedge clk);
    idle_inputs();
    in_valid = 1'b1; in_dst_en = 4'b0001; in_dst = {5'd0, 5'd0, 5'd0, 5'd7};
    fl_preg = {6'd0, 6'd0, 6'd0, 6'd50};
    restore_en = 1'b1; restore_areg = 5'd7; restore_preg = 6'd33;
    #1;
    check_and_commit("restore");
    readback("R9");

    // Sweep over a narrow register set with mixed stalls and restores.
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 9) != 0);
      out_ready = ($urandom_range(0, 7) != 0);
      restore_en = ($urandom_range(0, 19) == 0);
      restore_areg = AW'($urandom_range(0, 7));
      restore_preg = PW'($urandom_range(0, 63));
      fl_avail = CW'($urandom_range(0, 5) > 4 ? $urandom_range(0, 3) : 4);
      for (int s = 0; s < IW; s++) begin
        in_src1[s] = AW'(n % 50 == 0 ? $urandom_range(0, 31) : $urandom_range(0, 5));
        in_src2[s] = AW'($urandom_range(0, 5));
        in_dst[s]  = AW'($urandom_range(0, 5));
        in_dst_en[s] = ($urandom_range(0, 3) != 0);
        fl_preg[s] = PW'($urandom_range(0, 63));
      end
      #1;
      check_and_commit("sweep");
    end
    readback("R6 final");
    finish_run();
  end

endmodule